// File: doc/BRIEF.md
# Six-Stage Integer ALU Pipeline

This block is one of two matching integer execution lanes. It accepts one issued micro-op per cycle. The micro-op carries an opcode, two source register numbers, a destination register number, a shift kind and amount for the second operand, a saturate request, a four-bit condition and a set-flags request. The op then moves through six fixed stages:

1. Operand read.
2. Barrel shift of the second operand.
3. ALU operation and flag generation.
4. Optional signed saturation.
5. Condition check and control-flow redirect.
6. Register-file writeback.

The register file is outside the block. The block presents two read addresses in the first stage and takes the read data back in the same cycle. It drives a single write port in the final stage. The block keeps the architectural condition flags and a sticky saturation bit. The fifth stage sees flags as if every older op had already completed, because it bypasses the flag result of the op in the writeback stage.

A taken branch raises a redirect request and squashes every younger op in flight. An external flush squashes everything that has not reached writeback. The issuer must avoid reading a register that an op still in flight will write, because the block has no operand forwarding.

Top module: `alu_pipe6`

## Requirements
- R1: After a synchronous active-low reset, no write and no redirect are signalled, and the flags and the sticky saturation bit read zero.
- R2: An op sampled with `iss_valid` at clock edge k writes back during the cycle that follows edge k+5. Writes appear in issue order, at most one per cycle.
- R3: The second operand is shifted before the ALU by the amount `iss_sh_amt` (0 to 31). The kind is set by `iss_sh_type`: 0 shifts left logically, 1 shifts right logically, 2 shifts right arithmetically, and 3 rotates right. An amount of 0 leaves the operand unchanged.
- R4: The opcode selects the operation: 0 add, 1 subtract (A minus B), 2 and, 3 or, 4 exclusive-or, 5 move B, 6 A and not B, 7 compare (subtract with no write), 8 branch (target A plus B, no write). Codes 9 to 15 act as move. Ops 7 and 8 never write a register.
- R5: `flags` is {N,Z,C,V}. N and Z come from the ALU result before saturation. For add, subtract, compare and branch, C is the unsigned carry out (for subtraction, 1 when A ≥ B unsigned) and V is the signed overflow. For every other op, C and V are 0. The flags update when a writing op has `iss_setf` set, and always for compare. A branch never updates them. The new value is visible from the cycle after writeback.
- R6: When `iss_sat` is set on an add or subtract that overflows as signed, the written result becomes 0x7FFFFFFF for an overflow past the top and 0x80000000 for an overflow past the bottom. `sat_sticky` is then set and stays set until reset.
- R7: Condition codes are evaluated as follows. 0 passes on Z and 1 on not Z. 2 passes on C and 3 on not C. 4 passes on N and 5 on not N. 6 passes on V and 7 on not V. 8 passes on C and not Z; 9 on not C or Z. 10 passes on N = V and 11 on N ≠ V. 12 passes on not Z and N = V; 13 on Z or N ≠ V. 14 always passes and 15 never does. An op whose condition fails makes no write, no flag change, no saturation mark and no redirect.
- R8: A branch whose condition passes raises `redirect_valid` for one cycle, in the cycle after edge k+4, with `redirect_pc` equal to A plus the shifted B. The ops issued at edges k+1 through k+5 are discarded.
- R9: `flush` sampled high at edge f discards the ops issued at edges f-5 through f. The op issued at edge f-6 still writes back.
- R10: The condition of an op is judged against the flags left by every older surviving op, including the op issued on the edge just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard every op not yet at writeback |
| iss_valid | input | 1 | Issued micro-op present |
| iss_op | input | 4 | Opcode |
| iss_src_a | input | REG_AW | First source register |
| iss_src_b | input | REG_AW | Second source register |
| iss_dst | input | REG_AW | Destination register |
| iss_sh_type | input | 2 | Shift kind for operand B |
| iss_sh_amt | input | $clog2(XLEN) | Shift amount |
| iss_sat | input | 1 | Saturate signed overflow |
| iss_cond | input | 4 | Condition code |
| iss_setf | input | 1 | Update flags |
| rf_raddr_a | output | REG_AW | Register read address A |
| rf_raddr_b | output | REG_AW | Register read address B |
| rf_rdata_a | input | XLEN | Register read data A (same cycle) |
| rf_rdata_b | input | XLEN | Register read data B (same cycle) |
| wr_en | output | 1 | Register write enable |
| wr_addr | output | REG_AW | Register write address |
| wr_data | output | XLEN | Register write data |
| flags | output | 4 | Architectural {N,Z,C,V} |
| sat_sticky | output | 1 | Sticky saturation indicator |
| redirect_valid | output | 1 | Taken-branch redirect request |
| redirect_pc | output | XLEN | Redirect target |

## Verification
The bench aims at the following corner cases, each paired with the failure it would expose:

- **Saturation limits.** Sums that cross the positive limit and the negative limit by one are run with saturation enabled. A wrong clamp polarity writes the wrong extreme. A missing sticky update leaves `sat_sticky` low.
- **Extreme shift amounts.** Shifts by 0 and by 31 are run for every shift kind. A shifter that mishandles them corrupts the sign fill or the rotate wrap.
- **Flag bypass.** A conditional op issued right behind a flag-setting op would act on stale flags without the bypass from the writeback stage.
- **Squash windows.** Branches and flushes are sent among dense traffic. A squash window that is off by one stage either lets a wrong-path write through or drops a write that should survive.

// File: rtl/alu6_pkg.sv
// alu6_pkg: shared encodings for the six-stage ALU lane.
// Assumes 4-bit opcodes and conditions; codes not listed decode as move.
package alu6_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_SUB = 4'd1;
    localparam logic [3:0] OP_AND = 4'd2;
    localparam logic [3:0] OP_ORR = 4'd3;
    localparam logic [3:0] OP_EOR = 4'd4;
    localparam logic [3:0] OP_MOV = 4'd5;
    localparam logic [3:0] OP_BIC = 4'd6;
    localparam logic [3:0] OP_CMP = 4'd7;
    localparam logic [3:0] OP_BR  = 4'd8;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // True when the opcode produces a register result.
    function automatic logic op_writes(input logic [3:0] op);
        return !(op == OP_CMP || op == OP_BR);
    endfunction

    // True when the opcode goes through the adder.
    function automatic logic op_arith(input logic [3:0] op);
        return op == OP_ADD || op == OP_SUB || op == OP_CMP || op == OP_BR;
    endfunction

endpackage

// File: rtl/alu6_shifter.sv
// alu6_shifter: combinational barrel shifter for operand B.
// Assumes the amount is below W; an amount of zero passes data through.
module alu6_shifter
    import alu6_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [1:0]    kind,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] wrap;

    // Select the shifted value for the requested kind.
    always_comb begin
        wrap = {din, din} >> amt;
        case (shift_e'(kind))
            SH_LSL:  dout = din << amt;
            SH_LSR:  dout = din >> amt;
            SH_ASR:  dout = W'($signed(din) >>> amt);
            default: dout = wrap[W-1:0];
        endcase
    end
endmodule

// File: rtl/alu6_exec.sv
// alu6_exec: combinational ALU with flag generation.
// Assumes subtraction is A + ~B + 1, so carry means "no borrow".
module alu6_exec
    import alu6_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    output logic [W-1:0] res,
    output flags_t       fl,
    output logic         ovf
);
    logic         is_sub;
    logic         arith;
    logic [W-1:0] bop;
    logic [W:0]   sum;

    // Compute the result, the signed overflow and the four flags.
    always_comb begin
        arith  = op_arith(op);
        is_sub = (op == OP_SUB) || (op == OP_CMP);
        bop    = is_sub ? ~b : b;
        sum    = {1'b0, a} + {1'b0, bop} + (W+1)'(is_sub);
        case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_BR: res = sum[W-1:0];
            OP_AND:  res = a & b;
            OP_ORR:  res = a | b;
            OP_EOR:  res = a ^ b;
            OP_BIC:  res = a & ~b;
            default: res = b;
        endcase
        ovf  = arith && (a[W-1] == bop[W-1]) && (sum[W-1] != a[W-1]);
        fl.n = res[W-1];
        fl.z = (res == '0);
        fl.c = arith & sum[W];
        fl.v = ovf;
    end
endmodule

// File: rtl/alu6_cond.sv
// alu6_cond: evaluates a 4-bit condition against a flag set.
// Assumes code 14 always passes and code 15 never passes.
module alu6_cond
    import alu6_pkg::*;
(
    input  logic [3:0] code,
    input  flags_t     f,
    output logic       pass
);
    // Decode the condition into a pass/fail bit.
    always_comb begin
        case (code)
            4'd0:  pass = f.z;
            4'd1:  pass = !f.z;
            4'd2:  pass = f.c;
            4'd3:  pass = !f.c;
            4'd4:  pass = f.n;
            4'd5:  pass = !f.n;
            4'd6:  pass = f.v;
            4'd7:  pass = !f.v;
            4'd8:  pass = f.c && !f.z;
            4'd9:  pass = !f.c || f.z;
            4'd10: pass = (f.n == f.v);
            4'd11: pass = (f.n != f.v);
            4'd12: pass = !f.z && (f.n == f.v);
            4'd13: pass = f.z || (f.n != f.v);
            4'd14: pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_pipe6.sv
// alu_pipe6: six-stage integer ALU lane (read, shift, ALU, saturate,
// condition/redirect, writeback). Assumes an external register file with
// same-cycle reads and no in-flight register hazards created by the issuer.
module alu_pipe6
    import alu6_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic [3:0]        iss_op,
    input  logic [REG_AW-1:0] iss_src_a,
    input  logic [REG_AW-1:0] iss_src_b,
    input  logic [REG_AW-1:0] iss_dst,
    input  logic [1:0]        iss_sh_type,
    input  logic [$clog2(XLEN)-1:0] iss_sh_amt,
    input  logic              iss_sat,
    input  logic [3:0]        iss_cond,
    input  logic              iss_setf,
    output logic [REG_AW-1:0] rf_raddr_a,
    output logic [REG_AW-1:0] rf_raddr_b,
    input  logic [XLEN-1:0]   rf_rdata_a,
    input  logic [XLEN-1:0]   rf_rdata_b,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [XLEN-1:0]   wr_data,
    output logic [3:0]        flags,
    output logic              sat_sticky,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);
    localparam int SW = $clog2(XLEN);
    localparam logic [XLEN-1:0] SAT_MAX = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] SAT_MIN = {1'b1, {(XLEN-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic [3:0]        op;
        logic [REG_AW-1:0] sa;
        logic [REG_AW-1:0] sb;
        logic [REG_AW-1:0] dst;
        logic [1:0]        sht;
        logic [SW-1:0]     sha;
        logic              sat;
        logic [3:0]        cond;
        logic              setf;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   res;
        flags_t            fl;
        logic              ovf;
        logic              sat_hit;
        logic              pass;
    } stage_t;

    stage_t st_rd, st_sh, st_ex, st_st, st_cf, st_wb;
    stage_t nx_rd, nx_sh, nx_ex, nx_st, nx_cf, nx_wb;

    flags_t          flags_q;
    flags_t          eff_flags;
    logic            sat_q;
    logic            flag_upd;
    logic            cf_pass;
    logic            kill_young;
    logic [XLEN-1:0] sh_out;
    logic [XLEN-1:0] ex_res;
    flags_t          ex_fl;
    logic            ex_ovf;

    alu6_shifter #(.W(XLEN), .SW(SW)) u_shift (
        .din  (st_sh.b),
        .kind (st_sh.sht),
        .amt  (st_sh.sha),
        .dout (sh_out)
    );

    alu6_exec #(.W(XLEN)) u_exec (
        .a   (st_ex.a),
        .b   (st_ex.b),
        .op  (st_ex.op),
        .res (ex_res),
        .fl  (ex_fl),
        .ovf (ex_ovf)
    );

    alu6_cond u_cond (
        .code (st_cf.cond),
        .f    (eff_flags),
        .pass (cf_pass)
    );

    // Writeback-stage effects and the flag bypass into the condition stage.
    always_comb begin
        wr_en     = st_wb.valid && st_wb.pass && op_writes(st_wb.op);
        wr_addr   = st_wb.dst;
        wr_data   = st_wb.res;
        flag_upd  = st_wb.valid && st_wb.pass &&
                    ((st_wb.op == OP_CMP) || (st_wb.setf && op_writes(st_wb.op)));
        eff_flags = flag_upd ? st_wb.fl : flags_q;
    end

    // Redirect request from the condition stage and the squash it causes.
    always_comb begin
        redirect_valid = st_cf.valid && cf_pass && (st_cf.op == OP_BR);
        redirect_pc    = st_cf.res;
        kill_young     = flush || redirect_valid;
    end

    // Next-state of every stage register.
    always_comb begin
        nx_rd       = '0;
        nx_rd.valid = iss_valid && !kill_young;
        nx_rd.op    = iss_op;
        nx_rd.sa    = iss_src_a;
        nx_rd.sb    = iss_src_b;
        nx_rd.dst   = iss_dst;
        nx_rd.sht   = iss_sh_type;
        nx_rd.sha   = iss_sh_amt;
        nx_rd.sat   = iss_sat;
        nx_rd.cond  = iss_cond;
        nx_rd.setf  = iss_setf;

        nx_sh       = st_rd;
        nx_sh.valid = st_rd.valid && !kill_young;
        nx_sh.a     = rf_rdata_a;
        nx_sh.b     = rf_rdata_b;

        nx_ex       = st_sh;
        nx_ex.valid = st_sh.valid && !kill_young;
        nx_ex.b     = sh_out;

        nx_st       = st_ex;
        nx_st.valid = st_ex.valid && !kill_young;
        nx_st.res   = ex_res;
        nx_st.fl    = ex_fl;
        nx_st.ovf   = ex_ovf;

        nx_cf         = st_st;
        nx_cf.valid   = st_st.valid && !kill_young;
        nx_cf.sat_hit = st_st.sat && st_st.ovf &&
                        (st_st.op == OP_ADD || st_st.op == OP_SUB);
        if (nx_cf.sat_hit) begin
            nx_cf.res = st_st.res[XLEN-1] ? SAT_MAX : SAT_MIN;
        end

        nx_wb       = st_cf;
        nx_wb.valid = st_cf.valid && !flush;
        nx_wb.pass  = cf_pass;
    end

    // Stage registers, architectural flags and sticky saturation bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_rd   <= '0;
            st_sh   <= '0;
            st_ex   <= '0;
            st_st   <= '0;
            st_cf   <= '0;
            st_wb   <= '0;
            flags_q <= '0;
            sat_q   <= 1'b0;
        end else begin
            st_rd <= nx_rd;
            st_sh <= nx_sh;
            st_ex <= nx_ex;
            st_st <= nx_st;
            st_cf <= nx_cf;
            st_wb <= nx_wb;
            if (flag_upd) begin
                flags_q <= st_wb.fl;
            end
            sat_q <= sat_q || (st_wb.valid && st_wb.pass && st_wb.sat_hit);
        end
    end

    // Register-read addresses and architectural outputs.
    always_comb begin
        rf_raddr_a = st_rd.sa;
        rf_raddr_b = st_rd.sb;
        flags      = flags_q;
        sat_sticky = sat_q;
    end
endmodule

// File: rtl/alu6_chk.sv
// alu6_chk: temporal checks on the lane's ports, bound to alu_pipe6.
// Assumes the synchronous active-low reset is asserted at time zero.
module alu6_chk (
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic wr_en,
    input logic redirect_valid,
    input logic sat_sticky
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wr_en && !redirect_valid && !sat_sticky));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky |=> sat_sticky);

    // R9
    flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!wr_en && !redirect_valid));

    // R8
    redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (!redirect_valid && !wr_en));
endmodule

bind alu_pipe6 alu6_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .wr_en          (wr_en),
    .redirect_valid (redirect_valid),
    .sat_sticky     (sat_sticky)
);

// File: tb/sim_alu_pipe6.sv
`timescale 1ns/1ps
module sim_alu_pipe6;
    localparam int N  = 1500;
    localparam int NC = N + 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic [4:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [1:0]  iss_sh_type = '0;
    logic [4:0]  iss_sh_amt = '0;
    logic        iss_sat = 1'b0, iss_setf = 1'b0;
    logic [3:0]  iss_cond = '0;
    logic [4:0]  rf_raddr_a, rf_raddr_b;
    logic [31:0] rf_rdata_a, rf_rdata_b;
    logic        wr_en, sat_sticky, redirect_valid;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data, redirect_pc;
    logic [3:0]  flags;

    logic [31:0] rf0 [32];
    assign rf_rdata_a = rf0[rf_raddr_a];
    assign rf_rdata_b = rf0[rf_raddr_b];

    alu_pipe6 u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .iss_sh_type(iss_sh_type), .iss_sh_amt(iss_sh_amt),
        .iss_sat(iss_sat), .iss_cond(iss_cond), .iss_setf(iss_setf),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flags(flags), .sat_sticky(sat_sticky),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    always #10 clk = ~clk;

    // Stimulus per issue edge
    bit          iv [N];
    logic [3:0]  iop [N];
    logic [4:0]  isa [N], isb [N], idst [N], isha [N];
    logic [1:0]  isht [N];
    bit          isat [N], isetf [N];
    logic [3:0]  icond [N];
    bit          ifl [NC];
    // Expected outputs per cycle
    bit          e_wr [NC];
    logic [4:0]  e_wa [NC];
    logic [31:0] e_wd [NC];
    string       e_tag [NC];
    bit          e_rd [NC];
    logic [31:0] e_rpc [NC];
    logic [3:0]  cumf [NC];
    bit          cumq [NC];
    bit          killr [NC];

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_shift(input logic [31:0] d, input logic [1:0] t, input logic [4:0] n);
        logic [31:0] r = d;
        for (int i = 0; i < int'(n); i++) begin
            case (t)
                2'd0: r = {r[30:0], 1'b0};
                2'd1: r = {1'b0, r[31:1]};
                2'd2: r = {r[31], r[31:1]};
                default: r = {r[0], r[31:1]};
            endcase
        end
        return r;
    endfunction

    // f is {N,Z,C,V}
    function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;            1: return !z;
            2: return cy;           3: return !cy;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return cy && !z;     9: return !cy || z;
            10: return n == v;      11: return n != v;
            12: return !z && n == v; 13: return z || n != v;
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic set_ins(input int k, input logic [3:0] op, input logic [4:0] a, input logic [4:0] b,
                           input logic [4:0] d, input logic [1:0] st, input logic [4:0] sh,
                           input bit sat, input logic [3:0] c, input bit sf);
        iv[k] = 1; iop[k] = op; isa[k] = a; isb[k] = b; idst[k] = d;
        isht[k] = st; isha[k] = sh; isat[k] = sat; icond[k] = c; isetf[k] = sf;
    endtask

    task automatic build_stimulus();
        void'($urandom(32'd20240611));
        rf0[0] = 32'h0; rf0[1] = 32'h1; rf0[2] = 32'h7FFF_FFFF; rf0[3] = 32'h8000_0000;
        rf0[4] = 32'hFFFF_FFFF; rf0[5] = 32'h1234_5678;
        for (int i = 6; i < 32; i++) rf0[i] = $urandom();
        for (int k = 0; k < NC; k++) ifl[k] = 0;
        for (int k = 0; k < N; k++) iv[k] = 0;
        // Directed corner cases
        set_ins(0, 4'd0, 2, 1, 16, 0, 0, 1, 14, 1);  // R6 positive overflow clamp, sets V
        set_ins(1, 4'd5, 0, 5, 17, 0, 0, 0, 6, 0);   // R10 VS right behind flag setter
        set_ins(2, 4'd1, 3, 1, 18, 0, 0, 1, 14, 0);  // R6 negative overflow clamp
        set_ins(3, 4'd0, 1, 1, 19, 0, 0, 0, 15, 0);  // R7 never
        set_ins(4, 4'd5, 0, 1, 20, 0, 31, 0, 14, 0); // R3 LSL 31
        set_ins(5, 4'd5, 0, 3, 21, 2, 31, 0, 14, 0); // R3 ASR 31
        set_ins(6, 4'd5, 0, 5, 22, 3, 4, 0, 14, 0);  // R3 ROR 4
        set_ins(7, 4'd5, 0, 4, 23, 1, 0, 0, 14, 0);  // R3 amount 0
        set_ins(8, 4'd7, 1, 1, 0, 0, 0, 0, 14, 0);   // R4 compare equal
        set_ins(9, 4'd8, 5, 1, 0, 0, 0, 0, 0, 0);    // R8 taken branch on EQ
        for (int k = 10; k < 21; k++) set_ins(k, 4'd0, 1, 5, 5'(14 + k), 0, 0, 0, 14, 1);
        ifl[20] = 1;                                  // R9 flush
        set_ins(21, 4'd6, 4, 5, 16, 0, 0, 0, 14, 1);
        set_ins(22, 4'd3, 5, 1, 17, 0, 0, 0, 14, 1);
        set_ins(23, 4'd2, 4, 5, 18, 0, 0, 0, 14, 1);
        for (int k = 24; k < N; k++) begin
            set_ins(k, 4'($urandom_range(0, 15)), 5'($urandom_range(0, 15)), 5'($urandom_range(0, 15)),
                    5'($urandom_range(16, 31)), 2'($urandom_range(0, 3)),
                    ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(0, 31)),
                    $urandom_range(0, 9) < 3, ($urandom_range(0, 1) == 0) ? 4'd14 : 4'($urandom_range(0, 15)),
                    $urandom_range(0, 1) == 1);
            iv[k] = $urandom_range(0, 99) < 85;
            ifl[k] = $urandom_range(0, 99) < 2;
        end
    endtask

    task automatic build_model();
        logic [3:0] f = 4'h0;
        bit q = 0;
        for (int c = 0; c < NC; c++) begin
            e_wr[c] = 0; e_wa[c] = '0; e_wd[c] = '0; e_tag[c] = "R2";
            e_rd[c] = 0; e_rpc[c] = '0; killr[c] = 0;
        end
        for (int k = 0; k < NC; k++) begin
            if (k < N && iv[k] && !killr[k]) begin
                bit kf = 0, kf4 = 0, pass, ovf, wrt, cy;
                logic [31:0] a, b, r;
                longint sa, sb, s;
                logic [3:0] op = iop[k];
                for (int g = k; g <= k + 5 && g < NC; g++)
                    if (ifl[g]) begin kf = 1; if (g <= k + 4) kf4 = 1; end
                a = rf0[isa[k]];
                b = ref_shift(rf0[isb[k]], isht[k], isha[k]);
                sa = longint'($signed(a));
                sb = longint'($signed(b));
                ovf = 0; cy = 0;
                case (op)
                    0, 8: begin r = a + b; s = sa + sb; cy = ({1'b0, a} + {1'b0, b}) > 33'hFFFF_FFFF; end
                    1, 7: begin r = a - b; s = sa - sb; cy = (a >= b); end
                    2: r = a & b;
                    3: r = a | b;
                    4: r = a ^ b;
                    6: r = a & ~b;
                    default: r = b;
                endcase
                if (op == 0 || op == 1 || op == 7 || op == 8)
                    ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                wrt = !(op == 7 || op == 8);
                pass = ref_cond(icond[k], f);
                if (op == 8 && pass && !kf4) begin
                    e_rd[k + 4] = 1; e_rpc[k + 4] = r;
                    for (int j = 1; j <= 5; j++) killr[k + j] = 1;
                end
                if (!kf && pass) begin
                    logic [3:0] nf = {r[31], r == 0, cy, ovf};
                    if (isat[k] && ovf && (op == 0 || op == 1)) begin
                        q = 1;
                        r = (s > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
                    end
                    if (wrt) begin
                        e_wr[k + 5] = 1; e_wa[k + 5] = idst[k]; e_wd[k + 5] = r;
                        e_tag[k + 5] = isat[k] ? "R6" : (icond[k] != 14) ? "R7" :
                                       (isha[k] != 0) ? "R3" : "R4";
                    end
                    if (op == 7 || (isetf[k] && wrt)) f = nf;
                end else begin
                    e_tag[k + 5] = kf ? "R9" : "R7";
                end
            end else if (k < N && iv[k]) begin
                e_tag[k + 5] = "R8";
            end
            cumf[k] = f; cumq[k] = q;
        end
    endtask

    task automatic drive(input int k);
        if (k < N) begin
            iss_valid = iv[k]; iss_op = iop[k]; iss_src_a = isa[k]; iss_src_b = isb[k];
            iss_dst = idst[k]; iss_sh_type = isht[k]; iss_sh_amt = isha[k];
            iss_sat = isat[k]; iss_cond = icond[k]; iss_setf = isetf[k];
        end else begin
            iss_valid = 0;
        end
        flush = ifl[k];
    endtask

    task automatic check_cycle(input int c);
        logic [3:0] ef = (c >= 6) ? cumf[c - 6] : 4'h0;
        bit eq = (c >= 6) ? cumq[c - 6] : 1'b0;
        check(wr_en === e_wr[c] && (!e_wr[c] || (wr_addr == e_wa[c] && wr_data == e_wd[c])), e_tag[c],
              {wr_en, 26'b0, wr_addr, wr_data}, {e_wr[c], 26'b0, e_wa[c], e_wd[c]});
        check(redirect_valid === e_rd[c] && (!e_rd[c] || redirect_pc == e_rpc[c]), "R8",
              {31'b0, redirect_valid, redirect_pc}, {31'b0, e_rd[c], e_rpc[c]});
        check(flags === ef, "R5/R10", {60'b0, flags}, {60'b0, ef});
        check(sat_sticky === eq, "R6", {63'b0, sat_sticky}, {63'b0, eq});
    endtask

    initial begin
        build_stimulus();
        build_model();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(!wr_en && !redirect_valid && flags == 4'h0 && !sat_sticky, "R1",
              {58'b0, wr_en, redirect_valid, flags}, 64'h0);
        rst_n = 1;
        for (int k = 0; k < NC; k++) begin
            drive(k);
            @(negedge clk);
            check_cycle(k);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule